// File: doc/BRIEF.md
# Fixed Off-Time Bridge Current Chopper

This block regulates the current in one full bridge of a two-winding motor driver using digital timing only. At the start of each on phase it takes a sample of a winding-sign input and turns on one diagonal of the bridge: the source switch of one leg and the sink switch of the other. That drives current through the winding in the sampled direction. A digitized comparator flag reports that the sensed current has reached its trip level. Once the flag is accepted, the bridge enters an off period of a programmed, fixed length and then turns back on.

During the off period the decay code selects how the winding current recirculates. Slow decay opens only the source switch. Fast decay opens both switches of the diagonal. Mixed decay runs fast for a programmed number of cycles at the start of the off period and then runs slow for the rest of it. The comparator flag is ignored for a programmed blanking window at the start of every on phase, so that switching transients do not cause false trips. When the winding sign reverses, a programmed dead phase with all four switches open is placed between the two polarities. An active-low enable and a fault input both force all outputs off. A fault also restarts the switching sequence. All intervals are cycle counts given on input buses.

Top module: `offtime_chopper`

## Requirements
- R1: During an on phase with latched sign 1, exactly the leg-A source and the leg-B sink are on. With sign 0, exactly the leg-B source and the leg-A sink are on. As the vector {src_a, snk_a, src_b, snk_b} these are 1001 and 0110.
- R2: An on phase ends only on an accepted trip flag. The off period that follows lasts `off_cycles_i` cycles, with 0 treated as 1, and the bridge then turns back on.
- R3: With decay code 00, or the reserved code 11, only the source opens during the whole off period. The diagonal's sink stays on, giving 0001 for sign 1 and 0100 for sign 0.
- R4: With decay code 01, all four outputs are off for the whole off period.
- R5: With decay code 10, the first min(`fast_cycles_i`, `off_cycles_i`) cycles of the off period are fast as in R4, and the remaining cycles are slow as in R3.
- R6: The trip flag is ignored during the first `blank_cycles_i` cycles of every on phase. With the flag held high, an on phase lasts exactly `blank_cycles_i`+1 cycles.
- R7: While `en_n_i` is high, all four outputs are off in the same cycle, and the phase timing keeps advancing as if the bridge were enabled.
- R8: While `fault_i` is high, all four outputs are off in the same cycle. After the fault clears, the sequence restarts exactly as it does after reset.
- R9: The sign input is sampled only when an on phase starts. A change during an on or off phase has no effect until the next on phase.
- R10: When the next on phase has the opposite sign and `dead_cycles_i` is nonzero, an all-off dead phase of `dead_cycles_i` cycles comes first. After reset or fault the start phase is all-off for max(`dead_cycles_i`,1) cycles.
- R11: While reset is asserted, all four outputs are off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| trip_i | input | 1 | Digitized current-trip comparator flag |
| decay_i | input | 2 | Decay code: 00 slow, 01 fast, 10 mixed, 11 slow |
| sign_i | input | 1 | Winding current sign for the next on phase |
| en_n_i | input | 1 | Active-low output enable |
| fault_i | input | 1 | Fault (over-temperature or undervoltage) |
| off_cycles_i | input | CNT_W | Fixed off-time in cycles |
| blank_cycles_i | input | CNT_W | Blanking window in cycles |
| fast_cycles_i | input | CNT_W | Fast portion of mixed decay in cycles |
| dead_cycles_i | input | DEAD_W | Dead phase on polarity reversal in cycles |
| src_a_o | output | 1 | Leg-A source switch enable |
| snk_a_o | output | 1 | Leg-A sink switch enable |
| src_b_o | output | 1 | Leg-B source switch enable |
| snk_b_o | output | 1 | Leg-B sink switch enable |

## Verification
The bench uses the default widths but keeps every interval small: off time 0 to 4, blanking 0 to 3, fast portion 0 to 5 and dead time 0 to 2, for all four decay codes and both signs. This covers the zero-length intervals, the clamp of the fast portion at the off time, and every point where a mixed off period can change from fast to slow. The expected output vector in each cycle is computed from the period arithmetic (start phase, blank+1 on cycles, off cycles), while a fixed pattern toggles the enable. Directed runs cover sign reversal with and without dead time, a fault in the middle of a run, and an on phase that never sees a trip.

// File: rtl/chop_pkg.sv
package chop_pkg;

   // Phase of the chopping cycle
   typedef enum logic [1:0] {
      PH_DEAD = 2'd0,   // all off: start-up or polarity reversal
      PH_ON   = 2'd1,   // diagonal driven
      PH_OFF  = 2'd2    // fixed off-time, decay per code
   } phase_e;

   // Decay code as seen on decay_i
   typedef enum logic [1:0] {
      DK_SLOW     = 2'd0,
      DK_FAST     = 2'd1,
      DK_MIXED    = 2'd2,
      DK_SLOW_ALT = 2'd3
   } decay_e;

endpackage

// File: rtl/chop_cfg_cond.sv
// Turns the raw interval inputs into the terminal counts used by the FSM
// and decoder. The fast portion is clamped to the off time here.
module chop_cfg_cond #(
   parameter int CNT_W   = 16,
   parameter int DEAD_W  = 8,
   parameter bit DEAD_EN = 1'b1
) (
   input  logic [CNT_W-1:0]  off_cycles_i,
   input  logic [CNT_W-1:0]  fast_cycles_i,
   input  logic [DEAD_W-1:0] dead_cycles_i,
   output logic [CNT_W-1:0]  off_last_o,
   output logic [CNT_W-1:0]  fast_eff_o,
   output logic [CNT_W-1:0]  dead_last_o,
   output logic              dead_active_o
);

   localparam int PAD_W = CNT_W - DEAD_W;

   if (PAD_W < 0) begin : g_bad_widths
      $error("chop_cfg_cond: DEAD_W must not exceed CNT_W");
   end

   // Off time of 0 behaves as 1 cycle: last count index is off-1, floored at 0
   assign off_last_o = (off_cycles_i == '0) ? '0 : off_cycles_i - 1'b1;

   // Fast portion never longer than the off time
   assign fast_eff_o = (fast_cycles_i > off_cycles_i) ? off_cycles_i : fast_cycles_i;

   if (DEAD_EN) begin : g_dead
      logic [CNT_W-1:0] dead_ext;
      if (PAD_W > 0) begin : g_pad
         assign dead_ext = {{PAD_W{1'b0}}, dead_cycles_i};
      end else begin : g_nopad
         assign dead_ext = dead_cycles_i;
      end
      assign dead_last_o   = (dead_ext == '0) ? '0 : dead_ext - 1'b1;
      assign dead_active_o = (dead_ext != '0);
   end else begin : g_nodead
      logic unused_dead;
      assign unused_dead   = ^dead_cycles_i;
      assign dead_last_o   = '0;
      assign dead_active_o = 1'b0;
   end

endmodule

// File: rtl/chop_phase_fsm.sv
// Phase sequencer: dead -> on -> off -> (dead on reversal) -> on ...
// One shared counter times whichever phase is active.
module chop_phase_fsm
   import chop_pkg::*;
#(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             fault_i,
   input  logic             trip_i,
   input  logic             sign_i,
   input  logic [CNT_W-1:0] blank_cycles_i,
   input  logic [CNT_W-1:0] off_last_i,
   input  logic [CNT_W-1:0] dead_last_i,
   input  logic             dead_active_i,
   output phase_e           phase_o,
   output logic [CNT_W-1:0] cnt_o,
   output logic             sign_o
);

   if (CNT_W < 2) begin : g_bad_cnt
      $error("chop_phase_fsm: CNT_W must be at least 2");
   end

   localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

   phase_e           phase_q;
   logic [CNT_W-1:0] cnt_q;
   logic             sign_q;

   logic blank_done, off_done, dead_done, reversal;

   assign blank_done = (cnt_q >= blank_cycles_i);
   assign off_done   = (cnt_q >= off_last_i);
   assign dead_done  = (cnt_q >= dead_last_i);
   assign reversal   = dead_active_i && (sign_i != sign_q);

   always_ff @(posedge clk) begin
      if (!rst_n || fault_i) begin
         phase_q <= PH_DEAD;
         cnt_q   <= '0;
         if (!rst_n) sign_q <= 1'b0;
      end else begin
         unique case (phase_q)
            PH_DEAD: begin
               if (dead_done) begin
                  phase_q <= PH_ON;
                  cnt_q   <= '0;
                  sign_q  <= sign_i;
               end else begin
                  cnt_q <= cnt_q + 1'b1;
               end
            end
            PH_ON: begin
               if (trip_i && blank_done) begin
                  phase_q <= PH_OFF;
                  cnt_q   <= '0;
               end else if (cnt_q != CNT_MAX) begin
                  cnt_q <= cnt_q + 1'b1;
               end
            end
            PH_OFF: begin
               if (off_done) begin
                  cnt_q <= '0;
                  if (reversal) begin
                     phase_q <= PH_DEAD;
                  end else begin
                     phase_q <= PH_ON;
                     sign_q  <= sign_i;
                  end
               end else begin
                  cnt_q <= cnt_q + 1'b1;
               end
            end
            default: begin
               phase_q <= PH_DEAD;
               cnt_q   <= '0;
            end
         endcase
      end
   end

   assign phase_o = phase_q;
   assign cnt_o   = cnt_q;
   assign sign_o  = sign_q;

   // R6: an on phase only ends once the blanking window has elapsed
   a_r6_blank_respected: assert property (@(posedge clk) disable iff (!rst_n)
      (phase_q == PH_OFF && $past(phase_q) == PH_ON) |-> ($past(cnt_q) >= $past(blank_cycles_i)));

   // R2: return to on from off only after the full off time
   a_r2_off_length: assert property (@(posedge clk) disable iff (!rst_n)
      (phase_q == PH_ON && $past(phase_q) == PH_OFF) |-> ($past(cnt_q) >= $past(off_last_i)));

   // R9: latched sign never changes inside an on or off phase
   a_r9_sign_held: assert property (@(posedge clk) disable iff (!rst_n)
      (phase_q != PH_DEAD && $past(phase_q) == phase_q) |-> $stable(sign_q));

endmodule

// File: rtl/chop_gate_decode.sv
// Maps phase, latched sign and decay code onto the four switch enables.
module chop_gate_decode
   import chop_pkg::*;
#(
   parameter int CNT_W = 16
) (
   input  phase_e           phase_i,
   input  logic [CNT_W-1:0] cnt_i,
   input  logic             sign_i,
   input  logic [1:0]       decay_i,
   input  logic [CNT_W-1:0] fast_eff_i,
   input  logic             en_n_i,
   input  logic             fault_i,
   output logic [1:0]       src_o,
   output logic [1:0]       snk_o
);

   decay_e mode;
   logic   fast_now, gate_ok;

   assign mode = decay_e'(decay_i);

   always_comb begin
      unique case (mode)
         DK_FAST:  fast_now = 1'b1;
         DK_MIXED: fast_now = (cnt_i < fast_eff_i);
         default:  fast_now = 1'b0;
      endcase
   end

   assign gate_ok = !en_n_i && !fault_i;

   // Leg 0 is A, leg 1 is B. Leg A sources when the sign is 1.
   for (genvar l = 0; l < 2; l++) begin : g_leg
      localparam logic SRC_SIGN = (l == 0);
      assign src_o[l] = gate_ok && (phase_i == PH_ON) && (sign_i == SRC_SIGN);
      assign snk_o[l] = gate_ok && (sign_i != SRC_SIGN) &&
                        ((phase_i == PH_ON) || (phase_i == PH_OFF && !fast_now));
   end

endmodule

// File: rtl/offtime_chopper.sv
module offtime_chopper
   import chop_pkg::*;
#(
   parameter int CNT_W   = 16,
   parameter int DEAD_W  = 8,
   parameter bit DEAD_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              trip_i,
   input  logic [1:0]        decay_i,
   input  logic              sign_i,
   input  logic              en_n_i,
   input  logic              fault_i,
   input  logic [CNT_W-1:0]  off_cycles_i,
   input  logic [CNT_W-1:0]  blank_cycles_i,
   input  logic [CNT_W-1:0]  fast_cycles_i,
   input  logic [DEAD_W-1:0] dead_cycles_i,
   output logic              src_a_o,
   output logic              snk_a_o,
   output logic              src_b_o,
   output logic              snk_b_o
);

   if (DEAD_W < 1) begin : g_bad_dead
      $error("offtime_chopper: DEAD_W must be at least 1");
   end

   logic [CNT_W-1:0] off_last, fast_eff, dead_last, cnt;
   logic             dead_active, sign_lat;
   phase_e           phase;
   logic [1:0]       src, snk;

   chop_cfg_cond #(.CNT_W(CNT_W), .DEAD_W(DEAD_W), .DEAD_EN(DEAD_EN)) u_cfg (
      .off_cycles_i  (off_cycles_i),
      .fast_cycles_i (fast_cycles_i),
      .dead_cycles_i (dead_cycles_i),
      .off_last_o    (off_last),
      .fast_eff_o    (fast_eff),
      .dead_last_o   (dead_last),
      .dead_active_o (dead_active)
   );

   chop_phase_fsm #(.CNT_W(CNT_W)) u_fsm (
      .clk            (clk),
      .rst_n          (rst_n),
      .fault_i        (fault_i),
      .trip_i         (trip_i),
      .sign_i         (sign_i),
      .blank_cycles_i (blank_cycles_i),
      .off_last_i     (off_last),
      .dead_last_i    (dead_last),
      .dead_active_i  (dead_active),
      .phase_o        (phase),
      .cnt_o          (cnt),
      .sign_o         (sign_lat)
   );

   chop_gate_decode #(.CNT_W(CNT_W)) u_dec (
      .phase_i    (phase),
      .cnt_i      (cnt),
      .sign_i     (sign_lat),
      .decay_i    (decay_i),
      .fast_eff_i (fast_eff),
      .en_n_i     (en_n_i),
      .fault_i    (fault_i),
      .src_o      (src),
      .snk_o      (snk)
   );

   assign src_a_o = src[0];
   assign snk_a_o = snk[0];
   assign src_b_o = src[1];
   assign snk_b_o = snk[1];

   // R1: never both switches of one leg
   a_r1_no_shoot_through: assert property (@(posedge clk) disable iff (!rst_n)
      !(src_a_o && snk_a_o) && !(src_b_o && snk_b_o));

   // R8: a fault seen at an edge leaves the sequencer in a fresh start phase
   a_r8_fault_restart: assert property (@(posedge clk) disable iff (!rst_n)
      $past(fault_i) |-> (phase == PH_DEAD && cnt == '0));

   // R10: with dead time set, one diagonal is never followed directly by the other
   if (DEAD_EN) begin : g_dead_chk
      a_r10_dead_gap: assert property (@(posedge clk) disable iff (!rst_n)
         ((dead_cycles_i != '0) && $past(src_a_o || snk_b_o)) |-> !(src_b_o || snk_a_o));
   end

endmodule

// File: tb/offtime_chopper_tb_top.sv
module offtime_chopper_tb_top;

   localparam int CLK_PERIOD = 10;
   localparam int CW = 16;
   localparam int DW = 8;
   localparam int SWEEP_LEN = 22;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic trip = 1'b0, sign = 1'b0, en_n = 1'b0, fault = 1'b0;
   logic [1:0] decay = 2'd0;
   logic [CW-1:0] off_c = '0, blank_c = '0, fast_c = '0;
   logic [DW-1:0] dead_c = '0;
   logic src_a, snk_a, src_b, snk_b;

   int n_cmp = 0, n_bad = 0, cyc = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   offtime_chopper #(.CNT_W(CW), .DEAD_W(DW)) dut_i (
      .clk(clk), .rst_n(rst_n), .trip_i(trip), .decay_i(decay), .sign_i(sign),
      .en_n_i(en_n), .fault_i(fault), .off_cycles_i(off_c), .blank_cycles_i(blank_c),
      .fast_cycles_i(fast_c), .dead_cycles_i(dead_c),
      .src_a_o(src_a), .snk_a_o(snk_a), .src_b_o(src_b), .snk_b_o(snk_b));

   function automatic logic [3:0] outs();
      return {src_a, snk_a, src_b, snk_b};
   endfunction

   task automatic check(string req, logic [3:0] exp);
      n_cmp++;
      if (outs() !== exp) begin
         n_bad++;
         $display("FAIL %s t=%0t actual=%b expected=%b", req, $time, outs(), exp);
      end
   endtask

   // Expected {src_a,snk_a,src_b,snk_b} at cycle t after reset/fault release, trip held high
   function automatic logic [3:0] model(int t, int mode, int dead, int blank,
                                        int off, int fast, bit dir);
      int d  = (dead == 0) ? 1 : dead;
      int b1 = blank + 1;
      int o  = (off == 0) ? 1 : off;
      int m, q, fe;
      bit fst;
      if (t < d) return 4'b0000;
      m = (t - d) % (b1 + o);
      if (m < b1) return dir ? 4'b1001 : 4'b0110;
      q  = m - b1;
      fe = (fast > off) ? off : fast;
      fst = (mode == 1) || (mode == 2 && q < fe);
      if (fst) return 4'b0000;
      return dir ? 4'b0001 : 4'b0100;
   endfunction

   function automatic string tag(int t, int mode, int dead, int blank, int off, bit dis);
      int d  = (dead == 0) ? 1 : dead;
      int b1 = blank + 1;
      int o  = (off == 0) ? 1 : off;
      int m;
      if (dis) return "R7";
      if (t < d) return "R10";
      m = (t - d) % (b1 + o);
      if (m < blank) return "R6";
      if (m < b1) return "R1";
      if (m == b1 + o - 1) return "R2";
      if (mode == 1) return "R4";
      if (mode == 2) return "R5";
      return "R3";
   endfunction

   // Apply configuration under reset; returns at the negedge where t=0
   task automatic start(int mode, int dead, int blank, int off, int fast, bit dir, bit tr);
      @(negedge clk);
      rst_n = 1'b0; fault = 1'b0; en_n = 1'b0;
      decay = 2'(mode); dead_c = DW'(dead); blank_c = CW'(blank);
      off_c = CW'(off); fast_c = CW'(fast); sign = dir; trip = tr;
      @(negedge clk);
      rst_n = 1'b1;
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 190000 && !done) begin
         done = 1'b1;
         n_cmp++; n_bad++;
         $display("FAIL watchdog actual=%0d cycles expected=<190000", cyc);
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      // R11: outputs off under reset
      repeat (2) @(negedge clk);
      #1 check("R11", 4'b0000);

      // Sweep: all decay codes, both signs, small intervals; en_n toggles (R7)
      for (int mode = 0; mode < 4; mode++)
       for (int dead = 0; dead < 3; dead++)
        for (int blank = 0; blank < 4; blank++)
         for (int off = 0; off < 5; off++)
          for (int fast = 0; fast < 6; fast++)
           for (int dir = 0; dir < 2; dir++) begin
              start(mode, dead, blank, off, fast, dir[0], 1'b1);
              for (int t = 0; t < SWEEP_LEN; t++) begin
                 bit dis = ((t % 7) == 5);
                 en_n = dis;
                 #1;
                 check(tag(t, mode, dead, blank, off, dis),
                       dis ? 4'b0000 : model(t, mode, dead, blank, off, fast, dir[0]));
                 @(negedge clk);
              end
              en_n = 1'b0;
           end

      // R9 + R10: sign flips mid on-phase, dead=2, blank=1, off=2, slow
      start(0, 2, 1, 2, 0, 1'b1, 1'b1);
      for (int t = 0; t < 12; t++) begin
         logic [3:0] e;
         if (t == 3) sign = 1'b0;
         #1;
         if (t < 2) e = 4'b0000;
         else if (t < 4) e = 4'b1001;
         else if (t < 6) e = 4'b0001;
         else if (t < 8) e = 4'b0000;
         else if (t < 10) e = 4'b0110;
         else e = 4'b0100;
         check((t == 3 || t == 4 || t == 5) ? "R9" : "R10", e);
         @(negedge clk);
      end

      // R9: same flip with dead=0 switches polarity with no gap
      start(0, 0, 1, 2, 0, 1'b1, 1'b1);
      for (int t = 0; t < 6; t++) begin
         logic [3:0] e;
         if (t == 2) sign = 1'b0;
         #1;
         if (t == 0) e = 4'b0000;
         else if (t < 3) e = 4'b1001;
         else if (t < 5) e = 4'b0001;
         else e = 4'b0110;
         check("R9", e);
         @(negedge clk);
      end

      // R8: fault mid-run, then restart as after reset
      start(0, 0, 0, 2, 0, 1'b1, 1'b1);
      for (int t = 0; t < 6; t++) begin
         if (t == 3) fault = 1'b1;
         #1;
         check("R8", (t >= 3) ? 4'b0000 : model(t, 0, 0, 0, 2, 0, 1'b1));
         @(negedge clk);
      end
      fault = 1'b0;
      for (int t = 0; t < 7; t++) begin
         #1;
         check("R8", model(t, 0, 0, 0, 2, 0, 1'b1));
         @(negedge clk);
      end

      // R2: without a trip the on phase persists; a trip then starts the off time
      start(2, 0, 0, 3, 1, 1'b0, 1'b0);
      for (int t = 0; t < 21; t++) begin
         #1;
         if (t == 20) check("R2", 4'b0110);
         if (t == 20) trip = 1'b1;
         @(negedge clk);
      end
      #1 check("R2", 4'b0000);   // mixed: first off cycle is fast
      @(negedge clk);
      #1 check("R2", 4'b0100);   // then slow

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule